// File: doc/BRIEF.md
# Parallel NOR flash command sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus and turns one request into the full list of bus cycles the flash expects. A request arrives on a valid/ready front end and is one of three kinds: query the device identity, program one word, or erase one 4 KiB sector. Every kind begins with a fixed pair of unlock writes. The rest of the write list depends on the command.

After a program or an erase, the block polls the target by reading it repeatedly and watching the status bit that toggles while the flash is busy. It then reads the written word back, or every word of the erased sector, and compares it with what is expected. The identity query enters identity mode, waits a settle time, reads the two identity codes, leaves identity mode and waits again. Each request ends with a one-cycle completion pulse that carries a 2-bit status code.

Top module: `nor_cmd_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, `reqReady` is 1, `doneValid` is 0, `flCeN`, `flWeN` and `flOeN` are all 1, and `flDqOe` is 0.
- R2: A program request (`reqOp`=1) issues exactly four writes, in this order: 0x00AA to word address 0x5555, 0x0055 to 0x2AAA, 0x00A0 to 0x5555, then `reqData` to `reqAddr`.
- R3: An erase request (`reqOp`=2) issues exactly six writes, in this order: 0x00AA@0x5555, 0x0055@0x2AAA, 0x0080@0x5555, 0x00AA@0x5555, 0x0055@0x2AAA, then 0x0030 to the sector base. The sector base is `reqAddr` with its low log2(SECTOR_WORDS) bits cleared.
- R4: An identity request (`reqOp`=0) writes 0x00AA@0x5555, 0x0055@0x2AAA, 0x0090@0x5555. It then reads word addresses 0 and 1, and finally writes 0x00AA@0x5555, 0x0055@0x2AAA, 0x00F0@0x5555. The status is 3 (wrong part) if the word read at address 0 is not MFR_CODE (0xBF) or the word read at address 1 is not DEV_CODE. Otherwise the status is 0 (OK).
- R5: Polling reads the target and compares bit 6 of each read with bit 6 of the read before it. The operation counts as complete when the two bits are equal, so an operation that toggles for a few reads and then stops finishes with status 0.
- R6: If POLL_LIMIT comparisons all differ, the status is 1 (timeout). The status stays 1 even when the verify reads that follow also mismatch.
- R7: After a program, the target word is read back. A value different from `reqData` gives status 2 (verify failure).
- R8: After an erase, every one of the SECTOR_WORDS words of the sector is read once and compared with all ones. Any mismatch gives status 2. A clean erase with no busy period therefore takes 2 poll reads plus SECTOR_WORDS verify reads.
- R9: On the flash bus, `flWeN` is low for exactly WP_CYCLES clocks and only while `flCeN` is low. Address and data stay stable while `flWeN` is low and in the clock after it rises. `flOeN` is low for exactly RD_CYCLES clocks per read. `flDqOe` is never 1 while `flOeN` is low.
- R10: A request is taken only when `reqReady` is 1, and `reqReady` drops in the cycle after acceptance. `doneValid` is a one-cycle pulse, and `reqReady` is 0 during it and 1 in the cycle after it.
- R11: After the write that enters identity mode, at least SETTLE_CYCLES clocks pass before the first identity read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOp | input | 2 | 0 identity query, 1 program word, 2 erase sector |
| reqAddr | input | AW | Target word address |
| reqData | input | DW | Word to program |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 OK, 1 timeout, 2 verify failure, 3 wrong part |
| flAddr | output | AW | Flash word address |
| flDqOut | output | DW | Data driven toward the flash |
| flDqOe | output | 1 | Enable for the data bus driver |
| flDqIn | input | DW | Data returned by the flash |
| flCeN | output | 1 | Chip enable, active low |
| flWeN | output | 1 | Write enable, active low |
| flOeN | output | 1 | Output enable, active low |

## Verification
The bench builds the block with a 16-bit word address, 32-byte sectors (16 words), two-clock write and read strobes, a settle time of 5 clocks and a poll limit of 6. A small sector keeps a full erase verify to 16 reads, so the read count can be checked word for word, and a bad word can be planted inside it. The short poll limit makes the timeout reachable with a flash model that is stuck busy, while a busy period of three or four reads still completes. A settle time of 5 is longer than the normal write-to-poll gap, so the gap measured before the first identity read shows whether the settle wait was inserted.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {A_U1, A_U2, A_TGT, A_SEC, A_VER, A_ID0, A_ID1} addrSelE;
  typedef enum logic [2:0] {D_AA, D_55, D_A0, D_80, D_30, D_90, D_F0, D_REQ} dataSelE;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phaseE;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_TIMEOUT = 2'd1, ST_VERIFY = 2'd2, ST_WRONG = 2'd3} statusE;
  typedef enum logic [1:0] {K_ID, K_PROG, K_ERASE, K_EXIT} kindE;
  typedef enum logic [2:0] {RK_ID0, RK_ID1, RK_POLLA, RK_POLLB, RK_VER} rdKindE;
  typedef enum logic [2:0] {S_IDLE, S_WR_GO, S_WR_WAIT, S_SETTLE, S_RD_GO, S_RD_WAIT, S_FIN} stateE;

  typedef struct packed {
    logic    start;
    logic    write;
    addrSelE addrSel;
    dataSelE dataSel;
    logic    ldReq;
    logic    clrOff;
    logic    incOff;
    logic    ldPrev;
  } strobeS;

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter int SECTOR_WORDS = 2048,
  parameter int WP_CYCLES    = 4,
  parameter int RD_CYCLES    = 4,
  parameter int MFR_CODE     = 'hBF,
  parameter int DEV_CODE     = 'h2782
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeS        strb,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic [DW-1:0] flDqIn,
  output logic          busDone,
  output logic          rdIsMfr,
  output logic          rdIsDev,
  output logic          rdMatchExp,
  output logic          toggleSame,
  output logic          offLast,
  output logic [AW-1:0] flAddr,
  output logic [DW-1:0] flDqOut,
  output logic          flDqOe,
  output logic          flCeN,
  output logic          flWeN,
  output logic          flOeN
);
  localparam int OFFW = $clog2(SECTOR_WORDS);
  localparam int MAXC = (WP_CYCLES > RD_CYCLES) ? WP_CYCLES : RD_CYCLES;
  localparam int BW   = $clog2(MAXC + 1);

  logic [AW-1:0] tgtAddr, curAddr, addrMux;
  logic [DW-1:0] tgtData, curData, dataMux, rdData;
  logic [OFFW-1:0] off;
  logic eraseMode, prevBit, isWr;
  phaseE phase;
  logic [BW-1:0] cnt, busLim;

  always_comb begin
    case (strb.addrSel)
      A_U1:    addrMux = AW'(32'h5555);
      A_U2:    addrMux = AW'(32'h2AAA);
      A_SEC:   addrMux = {tgtAddr[AW-1:OFFW], {OFFW{1'b0}}};
      A_VER:   addrMux = {tgtAddr[AW-1:OFFW], off};
      A_ID0:   addrMux = '0;
      A_ID1:   addrMux = AW'(1);
      default: addrMux = tgtAddr;
    endcase
    case (strb.dataSel)
      D_AA:    dataMux = DW'(8'hAA);
      D_55:    dataMux = DW'(8'h55);
      D_A0:    dataMux = DW'(8'hA0);
      D_80:    dataMux = DW'(8'h80);
      D_30:    dataMux = DW'(8'h30);
      D_90:    dataMux = DW'(8'h90);
      D_F0:    dataMux = DW'(8'hF0);
      default: dataMux = tgtData;
    endcase
  end

  // request registers, sector offset, last poll bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtAddr <= '0; tgtData <= '0; eraseMode <= 1'b0; off <= '0; prevBit <= 1'b0;
    end else begin
      if (strb.ldReq) begin
        tgtAddr <= reqAddr; tgtData <= reqData; eraseMode <= (reqOp == 2'd2);
      end
      if (strb.clrOff) off <= '0;
      else if (strb.incOff) off <= off + 1'b1;
      if (strb.ldPrev) prevBit <= rdData[6];
    end
  end

  assign busLim = isWr ? BW'(WP_CYCLES - 1) : BW'(RD_CYCLES - 1);

  // bus cycle engine
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; cnt <= '0; isWr <= 1'b0; curAddr <= '0; curData <= '0;
      rdData <= '0; busDone <= 1'b0;
    end else begin
      busDone <= 1'b0;
      case (phase)
        PH_IDLE: if (strb.start) begin
          isWr <= strb.write; curAddr <= addrMux; curData <= dataMux; cnt <= '0;
          phase <= strb.write ? PH_SETUP : PH_STROBE;
        end
        PH_SETUP: phase <= PH_STROBE;
        PH_STROBE: begin
          if (cnt == busLim) begin
            if (isWr) phase <= PH_HOLD;
            else begin
              rdData <= flDqIn; busDone <= 1'b1; phase <= PH_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin busDone <= 1'b1; phase <= PH_IDLE; end
      endcase
    end
  end

  assign flAddr     = curAddr;
  assign flDqOut    = curData;
  assign flDqOe     = isWr && (phase != PH_IDLE);
  assign flCeN      = (phase != PH_STROBE);
  assign flWeN      = !((phase == PH_STROBE) && isWr);
  assign flOeN      = !((phase == PH_STROBE) && !isWr);
  assign rdIsMfr    = (rdData == DW'(MFR_CODE));
  assign rdIsDev    = (rdData == DW'(DEV_CODE));
  assign rdMatchExp = eraseMode ? (rdData == {DW{1'b1}}) : (rdData == tgtData);
  assign toggleSame = (rdData[6] == prevBit);
  assign offLast    = (off == {OFFW{1'b1}});

endmodule

// File: rtl/nor_seq_ctl.sv
module nor_seq_ctl
  import nor_seq_pkg::*;
#(
  parameter int POLL_LIMIT    = 100000,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       busDone,
  input  logic       rdIsMfr,
  input  logic       rdIsDev,
  input  logic       rdMatchExp,
  input  logic       toggleSame,
  input  logic       offLast,
  output logic       reqReady,
  output logic       doneValid,
  output logic [1:0] doneStatus,
  output strobeS     strb
);
  localparam int MAXC = (POLL_LIMIT > SETTLE_CYCLES) ? POLL_LIMIT : SETTLE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  stateE   state;
  kindE    kind;
  rdKindE  rk;
  statusE  status;
  logic [2:0] step, lastStep;
  logic [CW-1:0] cnt;
  addrSelE stepAddr, rdAddr;
  dataSelE stepData;
  logic pollLast;

  // write list for each command kind
  always_comb begin
    stepAddr = A_U1; stepData = D_AA;
    if (step == 3'd1 || (kind == K_ERASE && step == 3'd4)) begin
      stepAddr = A_U2; stepData = D_55;
    end else if (step == 3'd2) begin
      case (kind)
        K_PROG:  stepData = D_A0;
        K_ERASE: stepData = D_80;
        K_ID:    stepData = D_90;
        default: stepData = D_F0;
      endcase
    end else if (kind == K_PROG && step == 3'd3) begin
      stepAddr = A_TGT; stepData = D_REQ;
    end else if (kind == K_ERASE && step == 3'd5) begin
      stepAddr = A_SEC; stepData = D_30;
    end
    case (kind)
      K_PROG:  lastStep = 3'd3;
      K_ERASE: lastStep = 3'd5;
      default: lastStep = 3'd2;
    endcase
    case (rk)
      RK_ID0:  rdAddr = A_ID0;
      RK_ID1:  rdAddr = A_ID1;
      RK_VER:  rdAddr = (kind == K_ERASE) ? A_VER : A_TGT;
      default: rdAddr = (kind == K_ERASE) ? A_SEC : A_TGT;
    endcase
  end

  assign pollLast = (cnt == CW'(POLL_LIMIT - 1));

  always_comb begin
    strb = '0;
    case (state)
      S_IDLE:  strb.ldReq = reqValid;
      S_WR_GO: begin
        strb.start = 1'b1; strb.write = 1'b1; strb.addrSel = stepAddr; strb.dataSel = stepData;
      end
      S_RD_GO: begin strb.start = 1'b1; strb.addrSel = rdAddr; end
      S_RD_WAIT: if (busDone) begin
        case (rk)
          RK_POLLA: strb.ldPrev = 1'b1;
          RK_POLLB: begin
            if (toggleSame || pollLast) strb.clrOff = 1'b1;
            else strb.ldPrev = 1'b1;
          end
          RK_VER: strb.incOff = (kind == K_ERASE) && !offLast;
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; kind <= K_ID; rk <= RK_ID0; status <= ST_OK; step <= '0; cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          case (reqOp)
            2'd1:    kind <= K_PROG;
            2'd2:    kind <= K_ERASE;
            default: kind <= K_ID;
          endcase
          step <= '0; status <= ST_OK; state <= S_WR_GO;
        end
        S_WR_GO: state <= S_WR_WAIT;
        S_WR_WAIT: if (busDone) begin
          cnt <= '0;
          if (step != lastStep) begin
            step <= step + 1'b1; state <= S_WR_GO;
          end else if (kind == K_ID || kind == K_EXIT) state <= S_SETTLE;
          else begin rk <= RK_POLLA; state <= S_RD_GO; end
        end
        S_SETTLE: begin
          if (cnt == CW'(SETTLE_CYCLES - 1)) begin
            if (kind == K_ID) begin rk <= RK_ID0; state <= S_RD_GO; end
            else state <= S_FIN;
          end else cnt <= cnt + 1'b1;
        end
        S_RD_GO: state <= S_RD_WAIT;
        S_RD_WAIT: if (busDone) begin
          state <= S_RD_GO;
          case (rk)
            RK_ID0: begin
              if (!rdIsMfr) status <= ST_WRONG;
              rk <= RK_ID1;
            end
            RK_ID1: begin
              if (!rdIsDev) status <= ST_WRONG;
              kind <= K_EXIT; step <= '0; state <= S_WR_GO;
            end
            RK_POLLA: rk <= RK_POLLB;
            RK_POLLB: begin
              if (toggleSame) rk <= RK_VER;
              else if (pollLast) begin status <= ST_TIMEOUT; rk <= RK_VER; end
              else cnt <= cnt + 1'b1;
            end
            default: begin
              if (!rdMatchExp && status == ST_OK) status <= ST_VERIFY;
              if (kind != K_ERASE || offLast) state <= S_FIN;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign reqReady   = (state == S_IDLE);
  assign doneValid  = (state == S_FIN);
  assign doneStatus = status;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW            = 20,
  parameter int DW            = 16,
  parameter int SECTOR_BYTES  = 4096,
  parameter int WP_CYCLES     = 4,
  parameter int RD_CYCLES     = 4,
  parameter int SETTLE_CYCLES = 64,
  parameter int POLL_LIMIT    = 100000,
  parameter int MFR_CODE      = 'hBF,
  parameter int DEV_CODE      = 'h2782
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [1:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  output logic          doneValid,
  output logic [1:0]    doneStatus,
  output logic [AW-1:0] flAddr,
  output logic [DW-1:0] flDqOut,
  output logic          flDqOe,
  input  logic [DW-1:0] flDqIn,
  output logic          flCeN,
  output logic          flWeN,
  output logic          flOeN
);
  localparam int SECTOR_WORDS = SECTOR_BYTES / (DW / 8);

  strobeS strb;
  logic busDone, rdIsMfr, rdIsDev, rdMatchExp, toggleSame, offLast;

  nor_seq_ctl #(.POLL_LIMIT(POLL_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES)) ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .busDone(busDone),
    .rdIsMfr(rdIsMfr), .rdIsDev(rdIsDev), .rdMatchExp(rdMatchExp),
    .toggleSame(toggleSame), .offLast(offLast), .reqReady(reqReady),
    .doneValid(doneValid), .doneStatus(doneStatus), .strb(strb)
  );

  nor_seq_dp #(
    .AW(AW), .DW(DW), .SECTOR_WORDS(SECTOR_WORDS), .WP_CYCLES(WP_CYCLES),
    .RD_CYCLES(RD_CYCLES), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .flDqIn(flDqIn), .busDone(busDone), .rdIsMfr(rdIsMfr),
    .rdIsDev(rdIsDev), .rdMatchExp(rdMatchExp), .toggleSame(toggleSame),
    .offLast(offLast), .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
    .flCeN(flCeN), .flWeN(flWeN), .flOeN(flOeN)
  );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqReady,
  input logic          doneValid,
  input logic [AW-1:0] flAddr,
  input logic [DW-1:0] flDqOut,
  input logic          flDqOe,
  input logic          flCeN,
  input logic          flWeN,
  input logic          flOeN
);
  // R1: idle means a quiet bus
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (flCeN && flWeN && flOeN && !flDqOe));

  // R9: write strobe only inside chip enable
  a_r9_we_in_ce: assert property (@(posedge clk) disable iff (!rstN)
    !flWeN |-> !flCeN);

  // R9: no drive while the flash drives
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    flDqOe |-> flOeN);

  // R9: address and data steady during the strobe
  a_r9_wr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!flWeN && $past(!flWeN)) |-> ($stable(flAddr) && $stable(flDqOut)));

  // R9: hold clock after the strobe rises
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flWeN) |-> (flDqOe && $stable(flAddr) && $stable(flDqOut)));

  // R10: completion is a single pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10: busy after acceptance, not ready during completion
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  a_r10_done_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);
endmodule

bind nor_cmd_seq nor_seq_chk #(.AW(AW), .DW(DW)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .doneValid(doneValid), .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe),
  .flCeN(flCeN), .flWeN(flWeN), .flOeN(flOeN)
);

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
  localparam int AW = 16, DW = 16, SB = 32, SW = 16, WP = 2, RD = 2, SETTLE = 5, PL = 6;
  localparam logic [15:0] DEV = 16'h2782;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqReady, doneValid, flDqOe, flCeN, flWeN, flOeN;
  logic [1:0] doneStatus;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flDqOut, flDqIn;

  always #2 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW), .SECTOR_BYTES(SB), .WP_CYCLES(WP), .RD_CYCLES(RD),
    .SETTLE_CYCLES(SETTLE), .POLL_LIMIT(PL), .DEV_CODE(32'h2782)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .doneValid(doneValid), .doneStatus(doneStatus),
    .flAddr(flAddr), .flDqOut(flDqOut), .flDqOe(flDqOe), .flDqIn(flDqIn),
    .flCeN(flCeN), .flWeN(flWeN), .flOeN(flOeN));

  // ---------------- flash model knobs (driven by the bench) ----------------
  int busyLen = 0;
  bit stuck = 0, badProg = 0, badErase = 0;
  logic [15:0] mfrVal = 16'h00BF, devVal = 16'h2782;

  // ---------------- flash model state ----------------
  logic [15:0] mem [0:65535];
  logic [15:0] logA [0:255];
  logic [15:0] logD [0:255];
  int logN = 0, readN = 0, busyLeft = 0, cyc = 0, weCnt = 0, oeCnt = 0;
  int lastWe = 0, lastOe = 0, weRise = 0, idGap = 0;
  bit prevWe = 1, prevOe = 1, tog = 0, idMode = 0, wroteSince = 0;
  int seq = 0;

  assign flDqIn = (busyLeft != 0 || stuck) ? {9'd0, tog, 6'd0} :
                  idMode ? (flAddr[0] ? devVal : mfrVal) : mem[flAddr];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!flWeN) weCnt <= weCnt + 1;
    if (!flOeN) oeCnt <= oeCnt + 1;
    if (prevOe && !flOeN) begin
      readN <= readN + 1;
      if (wroteSince) begin idGap <= cyc - weRise; wroteSince <= 0; end
      if (stuck) tog <= ~tog;
      else if (busyLeft > 0) begin tog <= ~tog; busyLeft <= busyLeft - 1; end
    end
    if (!prevOe && flOeN) begin lastOe <= oeCnt; oeCnt <= 0; end
    if (!prevWe && flWeN) begin
      lastWe <= weCnt; weCnt <= 0; weRise <= cyc; wroteSince <= 1;
      logA[logN[7:0]] <= flAddr; logD[logN[7:0]] <= flDqOut; logN <= logN + 1;
      case (seq)
        0: if (flAddr == 16'h5555 && flDqOut == 16'h00AA) seq <= 1;
           else if (flDqOut == 16'h00F0) idMode <= 0;
        1: seq <= (flAddr == 16'h2AAA && flDqOut == 16'h0055) ? 2 : 0;
        2: begin
          seq <= 0;
          if (flAddr == 16'h5555) case (flDqOut)
            16'h00A0: seq <= 3;
            16'h0080: seq <= 4;
            16'h0090: idMode <= 1;
            16'h00F0: idMode <= 0;
            default: ;
          endcase
        end
        3: begin
          mem[flAddr] <= badProg ? (flDqOut ^ 16'h0001) : flDqOut;
          busyLeft <= busyLen; seq <= 0;
        end
        4: seq <= (flAddr == 16'h5555 && flDqOut == 16'h00AA) ? 5 : 0;
        5: seq <= (flAddr == 16'h2AAA && flDqOut == 16'h0055) ? 6 : 0;
        default: begin
          seq <= 0;
          if (flDqOut == 16'h0030) begin
            for (int i = 0; i < SW; i++)
              mem[{flAddr[15:4], 4'(i)}] <= (badErase && i == 7) ? 16'hFFFE : 16'hFFFF;
            busyLeft <= busyLen;
          end
        end
      endcase
    end
    prevWe <= flWeN;
    prevOe <= flOeN;
  end

  // ---------------- checking ----------------
  int errs = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int opLog, opRead;
  logic [1:0] opSt;

  task automatic doOp(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d);
    int w;
    while (!reqReady) @(negedge clk);
    opLog = logN; opRead = readN;
    reqOp = op; reqAddr = a; reqData = d; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R10 ready after accept", reqReady, 0);
    w = 0;
    while (!doneValid && w < 5000) begin @(negedge clk); w++; end
    chk(w < 5000, "R10 completion seen", w, 5000);
    opSt = doneStatus;
    @(negedge clk);
    chk(!doneValid && reqReady, "R10 pulse ends, ready again", {doneValid, reqReady}, 1);
  endtask

  task automatic chkWr(input int idx, input logic [15:0] a, input logic [15:0] d, input string req);
    chk(logA[(opLog + idx) % 256] == a && logD[(opLog + idx) % 256] == d, req,
        {logA[(opLog + idx) % 256], logD[(opLog + idx) % 256]}, {a, d});
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic [3:0]  busy;
    logic        stk;
    logic        bp;
    logic        be;
    logic [15:0] mfr;
    logic [15:0] dev;
    logic [1:0]  exp;
  } vecT;

  localparam vecT VEC [10] = '{
    '{2'd1, 16'h0123, 16'h1234, 4'd3, 1'b0, 1'b0, 1'b0, 16'h00BF, 16'h2782, 2'd0}, // R5 busy then done
    '{2'd1, 16'h0200, 16'hA5C3, 4'd0, 1'b0, 1'b0, 1'b0, 16'h00BF, 16'h2782, 2'd0}, // R5 not busy
    '{2'd1, 16'h0300, 16'h5555, 4'd0, 1'b0, 1'b1, 1'b0, 16'h00BF, 16'h2782, 2'd2}, // R7 bad readback
    '{2'd1, 16'h0400, 16'h0F0F, 4'd0, 1'b1, 1'b0, 1'b0, 16'h00BF, 16'h2782, 2'd1}, // R6 stuck busy
    '{2'd2, 16'h0437, 16'h0000, 4'd4, 1'b0, 1'b0, 1'b0, 16'h00BF, 16'h2782, 2'd0}, // R8 clean erase
    '{2'd2, 16'h0840, 16'h0000, 4'd0, 1'b0, 1'b0, 1'b1, 16'h00BF, 16'h2782, 2'd2}, // R8 bad word
    '{2'd2, 16'h0900, 16'h0000, 4'd0, 1'b1, 1'b0, 1'b1, 16'h00BF, 16'h2782, 2'd1}, // R6 timeout wins
    '{2'd0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b0, 1'b0, 16'h00BF, 16'h2782, 2'd0}, // R4 right part
    '{2'd0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b0, 1'b0, 16'h00BE, 16'h2782, 2'd3}, // R4 bad maker
    '{2'd0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b0, 1'b0, 16'h00BF, 16'h2783, 2'd3}  // R4 bad device
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(reqReady && !doneValid, "R1 handshake in reset", {reqReady, doneValid}, 2);
    rstN = 1'b1;
    @(negedge clk);
    chk(flCeN && flWeN && flOeN && !flDqOe, "R1 bus idle after reset",
        {flCeN, flWeN, flOeN, flDqOe}, 4'b1110);
    chk(reqReady && !doneValid, "R1 ready after reset", {reqReady, doneValid}, 2);

    for (int v = 0; v < 10; v++) begin
      busyLen = VEC[v].busy; stuck = VEC[v].stk; badProg = VEC[v].bp;
      badErase = VEC[v].be; mfrVal = VEC[v].mfr; devVal = VEC[v].dev;
      doOp(VEC[v].op, VEC[v].addr, VEC[v].data);
      chk(opSt == VEC[v].exp, $sformatf("vector %0d status (R4 R5 R6 R7 R8)", v), opSt, VEC[v].exp);
    end
    stuck = 0; badProg = 0; badErase = 0; busyLen = 0; mfrVal = 16'h00BF; devVal = DEV;

    // R2 program write order
    doOp(2'd1, 16'h0A11, 16'h0F0F);
    chk(logN - opLog == 4, "R2 write count", logN - opLog, 4);
    chkWr(0, 16'h5555, 16'h00AA, "R2 write 1");
    chkWr(1, 16'h2AAA, 16'h0055, "R2 write 2");
    chkWr(2, 16'h5555, 16'h00A0, "R2 write 3");
    chkWr(3, 16'h0A11, 16'h0F0F, "R2 write 4");
    chk(opSt == 2'd0, "R2 status", opSt, 0);
    // R9 strobe lengths
    chk(lastWe == WP, "R9 write strobe length", lastWe, WP);
    chk(lastOe == RD, "R9 read strobe length", lastOe, RD);

    // R3 erase write order, R8 read count
    doOp(2'd2, 16'h0B2C, 16'h0000);
    chk(logN - opLog == 6, "R3 write count", logN - opLog, 6);
    chkWr(0, 16'h5555, 16'h00AA, "R3 write 1");
    chkWr(1, 16'h2AAA, 16'h0055, "R3 write 2");
    chkWr(2, 16'h5555, 16'h0080, "R3 write 3");
    chkWr(3, 16'h5555, 16'h00AA, "R3 write 4");
    chkWr(4, 16'h2AAA, 16'h0055, "R3 write 5");
    chkWr(5, 16'h0B20, 16'h0030, "R3 write 6");
    chk(readN - opRead == 2 + SW, "R8 reads per erase", readN - opRead, 2 + SW);

    // R4 identity write list, R11 settle gap
    doOp(2'd0, 16'h0000, 16'h0000);
    chk(logN - opLog == 6 && readN - opRead == 2, "R4 cycle counts",
        {logN - opLog, readN - opRead}, {32'd6, 32'd2});
    chkWr(2, 16'h5555, 16'h0090, "R4 enter write");
    chkWr(5, 16'h5555, 16'h00F0, "R4 exit write");
    chk(idGap >= SETTLE, "R11 settle before identity read", idGap, SETTLE);
    chk(opSt == 2'd0, "R4 status", opSt, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule